// File: doc/BRIEF.md
# Video Gain and Clamp Controller

This block closes the digital side of the level-control loops that sit ahead of a video ADC. It watches the 9-bit digitized samples together with the line timing strobes. From them it produces an 8-bit gain code for the analog amplifier and a three-way clamp command (raise, lower or hold) for the black-level clamp. Every decision is taken once per line, on the line-start strobe, and is based on what was seen during the line that has just ended.

In automatic mode the gain follows the average level measured inside the sync-tip window, moving one code per line toward the target. A sample that reaches the overshoot threshold anywhere in the line forces a one-code reduction instead. A control bit, or a component-type source, replaces the loop with a host-written gain. The clamp loop compares the back-porch average with a black target. While vertical blanking is flagged, both outputs stay where they are and samples are ignored. Four registers are written through a plain write port.

Top module: `vid_level_ctrl`

## Requirements
- R1: After reset, gain_o is 8'h80 (GAIN_RST) and clamp_o is hold (2'b00). The clamp encoding is 2'b00 hold, 2'b01 raise, 2'b10 lower. The reset register values are: manual select 0, manual gain 8'h80, sync target 9'h040, black target 9'h080.
- R2: gain_o and clamp_o change only on the clock edge at which line_start_i is high. Register writes and samples in other cycles leave both outputs unchanged.
- R3: In automatic mode, at line start, the gain rises by one if the mean of the previous line's sync-window samples is above the sync target and falls by one if it is below. It holds if the mean equals the target or if the window held no samples. The gain saturates at 0 and 255.
- R4: Samples outside the sync window do not take part in the gain comparison, and samples outside the back-porch window do not take part in the clamp comparison.
- R5: When the manual select bit (address 0, bit 0) is set, each line start loads gain_o with the manual gain register (address 1, bits 7:0). Peak and sync results are ignored.
- R6: While comp_mode_i is high at line start, the gain is loaded from the manual gain register regardless of the select bit.
- R7: In automatic mode, if any sample of the previous line was at or above 9'h1F0, the gain falls by one at line start, saturating at 0. This takes priority over a sync-window increase.
- R8: At line start the clamp command becomes raise if the previous line's back-porch mean is below the black target, lower if it is above, and hold if it is equal or the window was empty.
- R9: If vblank_i is high at line start, gain_o and clamp_o keep their values. Samples taken while vblank_i is high add nothing to the averages or to peak detection.
- R10: Address 2 writes the 9-bit sync target and address 3 writes the 9-bit black target. A new target takes effect at the next line start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | 9 | Unsigned ADC sample, one per clock |
| sync_win_i | input | 1 | Sync-tip measurement window |
| bp_win_i | input | 1 | Back-porch measurement window |
| vblank_i | input | 1 | Vertical blanking flag |
| line_start_i | input | 1 | One-cycle strobe at the start of each line |
| comp_mode_i | input | 1 | Component-type source, forces manual gain |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address |
| wr_data_i | input | 9 | Register write data |
| gain_o | output | 8 | Amplifier gain code |
| clamp_o | output | 2 | Clamp command |

## Verification
The bench builds the block with CNT_W = 4, so each window counter holds at most 15 samples. This keeps the sum-versus-target products small enough for the bench to predict exactly. With that size, a sweep of the sync and back-porch levels over all 512 sample codes runs in a few thousand cycles. The sweep crosses both targets and the overshoot threshold. Long runs of one-sided lines then drive the gain against both rails.

// File: rtl/vlc_pkg.sv
package vlc_pkg;
  typedef enum logic [1:0] {
    CLAMP_HOLD = 2'b00,
    CLAMP_UP   = 2'b01,
    CLAMP_DOWN = 2'b10
  } clamp_cmd_e;

  typedef enum logic [1:0] {
    CMP_NONE = 2'b00,
    CMP_LT   = 2'b01,
    CMP_EQ   = 2'b10,
    CMP_GT   = 2'b11
  } cmp_e;
endpackage

// File: rtl/vlc_win_acc.sv
module vlc_win_acc
  import vlc_pkg::*;
#(
  parameter int DW    = 9,
  parameter int CNT_W = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          restart_i,
  input  logic          en_i,
  input  logic [DW-1:0] sample_i,
  input  logic [DW-1:0] target_i,
  output cmp_e          cmp_o
);
  localparam int SW = DW + CNT_W;

  logic [CNT_W-1:0] cnt_q;
  logic [SW-1:0]    sum_q;
  logic [SW-1:0]    smp_ext;
  logic [SW-1:0]    prod;
  logic             full;

  assign smp_ext = SW'(sample_i);
  assign full    = &cnt_q;

  // window stops counting when full so the sum cannot wrap
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sum_q <= '0;
    end else if (restart_i) begin
      cnt_q <= en_i ? CNT_W'(1) : '0;
      sum_q <= en_i ? smp_ext : '0;
    end else if (en_i && !full) begin
      cnt_q <= cnt_q + CNT_W'(1);
      sum_q <= sum_q + smp_ext;
    end
  end

  // mean vs target without a divider: sum against target * count
  assign prod = SW'(target_i) * SW'(cnt_q);

  always_comb begin
    if (cnt_q == '0)       cmp_o = CMP_NONE;
    else if (sum_q > prod) cmp_o = CMP_GT;
    else if (sum_q < prod) cmp_o = CMP_LT;
    else                   cmp_o = CMP_EQ;
  end

  // R4
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !restart_i |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + CNT_W'(1)));
endmodule

// File: rtl/vlc_regs.sv
module vlc_regs #(
  parameter int              DW        = 9,
  parameter int              GW        = 8,
  parameter logic [GW-1:0]   GAIN_RST  = 8'h80,
  parameter logic [DW-1:0]   SYNC_RST  = 9'h040,
  parameter logic [DW-1:0]   BLACK_RST = 9'h080
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [1:0]    wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  output logic          man_sel_o,
  output logic [GW-1:0] man_gain_o,
  output logic [DW-1:0] sync_tgt_o,
  output logic [DW-1:0] black_tgt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      man_sel_o   <= 1'b0;
      man_gain_o  <= GAIN_RST;
      sync_tgt_o  <= SYNC_RST;
      black_tgt_o <= BLACK_RST;
    end else if (wr_en_i) begin
      case (wr_addr_i)
        2'd0:    man_sel_o   <= wr_data_i[0];
        2'd1:    man_gain_o  <= wr_data_i[GW-1:0];
        2'd2:    sync_tgt_o  <= wr_data_i;
        default: black_tgt_o <= wr_data_i;
      endcase
    end
  end
endmodule

// File: rtl/vlc_gain_loop.sv
module vlc_gain_loop
  import vlc_pkg::*;
#(
  parameter int            GW       = 8,
  parameter logic [GW-1:0] GAIN_RST = 8'h80
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          step_i,
  input  logic          load_i,
  input  logic [GW-1:0] load_val_i,
  input  logic          peak_i,
  input  cmp_e          cmp_i,
  output logic [GW-1:0] gain_o
);
  localparam logic [GW-1:0] GMAX = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gain_o <= GAIN_RST;
    end else if (step_i) begin
      if (load_i) begin
        gain_o <= load_val_i;
      end else if (peak_i) begin
        if (gain_o != '0) gain_o <= gain_o - GW'(1);
      end else begin
        case (cmp_i)
          CMP_GT:  if (gain_o != GMAX) gain_o <= gain_o + GW'(1);
          CMP_LT:  if (gain_o != '0)   gain_o <= gain_o - GW'(1);
          default: ;
        endcase
      end
    end
  end

  // R3
  gain_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i) |=> ({1'b0, gain_o} == {1'b0, $past(gain_o)}) ||
                            ({1'b0, gain_o} == {1'b0, $past(gain_o)} + (GW+1)'(1)) ||
                            ({1'b0, gain_o} + (GW+1)'(1) == {1'b0, $past(gain_o)}));
  // R7
  peak_down_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && peak_i && gain_o != '0) |=> gain_o < $past(gain_o));
  // R5
  man_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && load_i) |=> gain_o == $past(load_val_i));
endmodule

// File: rtl/vid_level_ctrl.sv
module vid_level_ctrl
  import vlc_pkg::*;
#(
  parameter int            DW        = 9,
  parameter int            GW        = 8,
  parameter int            CNT_W     = 6,
  parameter logic [DW-1:0] PEAK_THR  = 9'h1F0,
  parameter logic [GW-1:0] GAIN_RST  = 8'h80,
  parameter logic [DW-1:0] SYNC_RST  = 9'h040,
  parameter logic [DW-1:0] BLACK_RST = 9'h080
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] sample_i,
  input  logic          sync_win_i,
  input  logic          bp_win_i,
  input  logic          vblank_i,
  input  logic          line_start_i,
  input  logic          comp_mode_i,
  input  logic          wr_en_i,
  input  logic [1:0]    wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  output logic [GW-1:0] gain_o,
  output logic [1:0]    clamp_o
);
  logic          man_sel;
  logic [GW-1:0] man_gain;
  logic [DW-1:0] sync_tgt, black_tgt;
  cmp_e          sync_cmp, bp_cmp;
  logic          peak_q, peak_now, step;
  clamp_cmd_e    clamp_q;

  assign step     = line_start_i && !vblank_i;
  assign peak_now = !vblank_i && (sample_i >= PEAK_THR);

  vlc_regs #(
    .DW(DW), .GW(GW), .GAIN_RST(GAIN_RST), .SYNC_RST(SYNC_RST), .BLACK_RST(BLACK_RST)
  ) i_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .man_sel_o(man_sel), .man_gain_o(man_gain),
    .sync_tgt_o(sync_tgt), .black_tgt_o(black_tgt)
  );

  vlc_win_acc #(.DW(DW), .CNT_W(CNT_W)) i_sync_acc (
    .clk_i, .rst_ni, .restart_i(line_start_i), .en_i(sync_win_i && !vblank_i),
    .sample_i, .target_i(sync_tgt), .cmp_o(sync_cmp)
  );

  vlc_win_acc #(.DW(DW), .CNT_W(CNT_W)) i_bp_acc (
    .clk_i, .rst_ni, .restart_i(line_start_i), .en_i(bp_win_i && !vblank_i),
    .sample_i, .target_i(black_tgt), .cmp_o(bp_cmp)
  );

  // overshoot seen anywhere in the line; the strobe cycle opens the next line
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           peak_q <= 1'b0;
    else if (line_start_i) peak_q <= peak_now;
    else if (peak_now)     peak_q <= 1'b1;
  end

  vlc_gain_loop #(.GW(GW), .GAIN_RST(GAIN_RST)) i_gain (
    .clk_i, .rst_ni, .step_i(step), .load_i(man_sel || comp_mode_i),
    .load_val_i(man_gain), .peak_i(peak_q), .cmp_i(sync_cmp), .gain_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clamp_q <= CLAMP_HOLD;
    end else if (step) begin
      case (bp_cmp)
        CMP_LT:  clamp_q <= CLAMP_UP;
        CMP_GT:  clamp_q <= CLAMP_DOWN;
        default: clamp_q <= CLAMP_HOLD;
      endcase
    end
  end

  assign clamp_o = clamp_q;

  // R2
  line_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !line_start_i |=> $stable(gain_o) && $stable(clamp_o));
  // R9
  vblank_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_start_i && vblank_i) |=> $stable(gain_o) && $stable(clamp_o));
  // R8
  clamp_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clamp_o != 2'b11);
endmodule

// File: tb/test_vid_level_ctrl.sv
module test_vid_level_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [8:0] sample = '0;
  logic       sync_win = 1'b0, bp_win = 1'b0, vblank = 1'b0, line_start = 1'b0;
  logic       comp_mode = 1'b0, wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [8:0] wr_data = '0;
  logic [7:0] gain;
  logic [1:0] clamp;

  int n_chk = 0, n_fail = 0;
  int m_gain = 128, m_clamp = 0, m_man = 128, m_sel = 0, m_stgt = 64, m_btgt = 128;
  int ssum = 0, scnt = 0, bsum = 0, bcnt = 0;
  bit pk = 0;
  bit done = 0;

  always #4 clk = ~clk;

  vid_level_ctrl #(.CNT_W(4)) i_vid_level_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .sample_i(sample), .sync_win_i(sync_win),
    .bp_win_i(bp_win), .vblank_i(vblank), .line_start_i(line_start),
    .comp_mode_i(comp_mode), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .gain_o(gain), .clamp_o(clamp)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1; wr_addr = 2'(a); wr_data = 9'(d);
    @(negedge clk);
    wr_en = 0;
    case (a)
      0: m_sel  = d & 1;
      1: m_man  = d & 8'hFF;
      2: m_stgt = d & 9'h1FF;
      default: m_btgt = d & 9'h1FF;
    endcase
  endtask

  task automatic drive(input int v, input bit sw, input bit bw, input bit vb);
    @(negedge clk);
    line_start = 0; sample = 9'(v); sync_win = sw; bp_win = bw; vblank = vb;
    if (!vb) begin
      if (sw && scnt < 15) begin ssum += v; scnt++; end
      if (bw && bcnt < 15) begin bsum += v; bcnt++; end
      if (v >= 'h1F0) pk = 1;
    end
  endtask

  task automatic strobe(input bit vb, input string tag);
    @(negedge clk);
    chk("R2 gain before strobe", gain, m_gain);
    chk("R2 clamp before strobe", clamp, m_clamp);
    line_start = 1; sample = '0; sync_win = 0; bp_win = 0; vblank = vb;
    if (!vb) begin
      if (m_sel != 0 || comp_mode) m_gain = m_man;
      else if (pk) m_gain = (m_gain == 0) ? 0 : m_gain - 1;
      else if (scnt > 0) begin
        if (ssum > m_stgt * scnt) m_gain = (m_gain == 255) ? 255 : m_gain + 1;
        else if (ssum < m_stgt * scnt) m_gain = (m_gain == 0) ? 0 : m_gain - 1;
      end
      if (bcnt == 0) m_clamp = 0;
      else if (bsum < m_btgt * bcnt) m_clamp = 1;
      else if (bsum > m_btgt * bcnt) m_clamp = 2;
      else m_clamp = 0;
    end
    ssum = 0; scnt = 0; bsum = 0; bcnt = 0; pk = 0;
    @(posedge clk); #1;
    chk({tag, " gain"}, gain, m_gain);
    chk({tag, " clamp"}, clamp, m_clamp);
    @(negedge clk);
    line_start = 0;
  endtask

  task automatic line(input int sv, input int sn, input int bv, input int bn,
                      input int av, input bit vb, input string tag);
    drive(0, 0, 0, vb);
    for (int i = 0; i < sn; i++) drive(sv, 1, 0, vb);
    drive(0, 0, 0, vb);
    for (int i = 0; i < bn; i++) drive(bv, 0, 1, vb);
    for (int i = 0; i < 3; i++) drive(av, 0, 0, vb);
    strobe(vb, tag);
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset gain", gain, 128);
    chk("R1 reset clamp", clamp, 0);

    // R3 R8 R7: sweep every code through both windows
    wr(2, 'h100);
    wr(3, 'h0C0);
    for (int v = 0; v < 512; v++) line(v, 2, (v * 7) % 512, 2, 'h10, 0, "R3/R7/R8 sweep");

    // R4: large values outside windows do not count
    wr(2, 'h080);
    line('h080, 3, 'h0C0, 3, 'h1E0, 0, "R4 out-of-window");
    // mixed sync samples, mean exactly on target
    drive(0, 0, 0, 0); drive('h070, 1, 0, 0); drive('h090, 1, 0, 0);
    strobe(0, "R3 equal mean");

    // R3 saturation high, peak priority over increase (R7)
    wr(2, 'h000);
    for (int i = 0; i < 140; i++) line('h020, 2, 0, 0, 0, 0, "R3 rise to 255");
    chk("R3 top rail", gain, 255);
    line('h020, 2, 0, 0, 'h1F0, 0, "R7 peak over rise");
    line('h020, 2, 0, 0, 'h1EF, 0, "R7 below threshold");

    // R10 sync target change, saturation low
    wr(2, 'h1FF);
    for (int i = 0; i < 260; i++) line('h010, 2, 'h0C0, 2, 0, 0, "R3 fall to 0");
    chk("R3 bottom rail", gain, 0);
    line('h010, 2, 'h0C0, 2, 'h1FF, 0, "R7 peak at zero");

    // R10 black target change
    wr(3, 'h040);
    line(0, 0, 'h041, 4, 0, 0, "R10 black target lower");
    wr(3, 'h050);
    line(0, 0, 'h041, 4, 0, 0, "R10 black target raise");

    // R9 vblank: hold outputs, ignore samples
    wr(2, 'h000);
    line('h100, 3, 'h000, 3, 'h1FF, 1, "R9 vblank hold");
    line('h000, 0, 'h050, 2, 0, 0, "R9 no carryover");

    // R5 manual select, R2 write mid-line does not move output
    wr(1, 'h033);
    wr(0, 1);
    drive(0, 0, 0, 0);
    chk("R2 after write", gain, m_gain);
    line('h100, 2, 'h050, 2, 'h1FF, 0, "R5 manual load");
    chk("R5 manual value", gain, 'h33);
    line('h100, 2, 'h050, 2, 'h1FF, 1, "R9 vblank manual");

    // R6 component forces manual
    wr(0, 0);
    wr(1, 'h05A);
    comp_mode = 1;
    line('h100, 2, 'h050, 2, 'h1FF, 0, "R6 component load");
    chk("R6 component value", gain, 'h5A);
    comp_mode = 0;
    line('h100, 2, 'h050, 2, 0, 0, "R3 auto resumes");

    finish_up();
  end
endmodule